// File: doc/BRIEF.md
# Oscillator Fine-Tune Code Distributor

This block spreads one global fine-tuning code across the load-control words of a ring oscillator's delay stages. Each of the `N_STAGES` stages takes a `WORD_W`-bit binary-weighted word, and the sum of all stage words always equals the global code. Because of this, every legal code selects a distinct total load, the frequency response is monotonic, and no two codes are redundant. Simply joining the stage words into one wide binary number would break all three properties.

A mode input chooses between two mappings, and the mode is sampled together with the code. In sequential fill, stage 0 ramps to full scale first, then stage 1, and so on. In interleaved stepping, the code adds one unit of load to each stage in turn, round-robin, so the stage words never differ by more than one.

The outputs are registered and change only on a clock edge where the code strobe is high, so all stage words switch in the same cycle. A code beyond the legal range is clamped to full load and raises a flag.

Top module: `ftd_code_distributor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces every stage word to zero and clears `out_of_range`.
- R2: For any legal code, the stage words add up to exactly that code in both modes. Each code step up therefore adds exactly one unit to the total.
- R3: In both modes, code 0 gives all-zero words, and code `N_STAGES*(2^WORD_W-1)` gives all-ones words. With the defaults (2 stages, 4 bits), that code is 30.
- R4: A code above `N_STAGES*(2^WORD_W-1)` gives all-ones words and sets `out_of_range` to 1. A later legal code clears `out_of_range` to 0.
- R5: The outputs change only on a rising clock edge where `code_vld` is 1. The new value is visible right after that edge. On edges where `code_vld` is 0, the outputs hold even if `code` or `ilv_mode` change.
- R6: With `ilv_mode`=0 (sequential), stage i gets the code minus i*(2^WORD_W-1), limited to the range 0 to 2^WORD_W-1. Stage i occupies bits [i*WORD_W +: WORD_W] of `stage_words`.
- R7: With `ilv_mode`=1 (interleaved), stage i gets floor((code + N_STAGES-1-i)/N_STAGES). The k-th unit step (counting from 0) goes to stage k mod N_STAGES. The bit positions are the same as in R6.
- R8: The mode is captured with the code on the same strobe. Two strobes with the same code but different modes give the mapping of each strobe's own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ilv_mode | input | 1 | 0 = sequential fill, 1 = interleaved stepping |
| code_vld | input | 1 | Strobe: load a new code on this edge |
| code | input | CODE_W | Global fine-tuning code |
| stage_words | output | N_STAGES*WORD_W | Registered per-stage load words, stage 0 in the low bits |
| out_of_range | output | 1 | Registered flag: last loaded code exceeded the legal maximum |

## Verification
A wrong stage mapping shows up at `stage_words` one edge after the strobe. It appears either as a word that disagrees with the step-by-step model, or as a sum that stays flat or jumps by two between adjacent codes. A missing or stale update of the state register is caught by looking at the outputs during idle cycles, where they must hold. A bad clamp or a stale flag is caught by a strobe just past the limit, followed by a legal code; the error shows up one cycle after each of those strobes.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

    typedef enum logic {
        MAP_SEQ = 1'b0,
        MAP_ILV = 1'b1
    } map_mode_e;

    function automatic int full_scale(input int word_w);
        return (1 << word_w) - 1;
    endfunction

endpackage

// File: rtl/ftd_seq_map.sv
module ftd_seq_map #(
    parameter int N_STAGES = 2,
    parameter int WORD_W   = 4,
    parameter int CODE_W   = 6
) (
    input  logic [CODE_W-1:0]          code_in,
    output logic [N_STAGES*WORD_W-1:0] words_out
);
    import ftd_pkg::*;

    localparam int STEP = full_scale(WORD_W);

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        always_comb begin
            int rem;
            rem = int'(code_in) - g * STEP;
            if (rem < 0)
                words_out[g*WORD_W +: WORD_W] = '0;
            else if (rem > STEP)
                words_out[g*WORD_W +: WORD_W] = WORD_W'(STEP);
            else
                words_out[g*WORD_W +: WORD_W] = WORD_W'(rem);
        end

        if (g > 0) begin : g_order
            always_comb begin
                if (words_out[g*WORD_W +: WORD_W] != '0)
                    AST_SEQ_FILL_ORDER: assert (words_out[(g-1)*WORD_W +: WORD_W] == WORD_W'(STEP)); // R6
            end
        end
    end

endmodule

// File: rtl/ftd_ilv_map.sv
module ftd_ilv_map #(
    parameter int N_STAGES = 2,
    parameter int WORD_W   = 4,
    parameter int CODE_W   = 6
) (
    input  logic [CODE_W-1:0]          code_in,
    output logic [N_STAGES*WORD_W-1:0] words_out
);

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        always_comb begin
            words_out[g*WORD_W +: WORD_W] =
                WORD_W'((int'(code_in) + N_STAGES - 1 - g) / N_STAGES);
        end

        if (g > 0) begin : g_balance
            always_comb begin
                AST_ILV_BALANCED: assert (
                    (words_out[(g-1)*WORD_W +: WORD_W] >= words_out[g*WORD_W +: WORD_W]) &&
                    (words_out[(g-1)*WORD_W +: WORD_W] - words_out[g*WORD_W +: WORD_W] <= WORD_W'(1))); // R7
            end
        end
    end

endmodule

// File: rtl/ftd_code_distributor.sv
module ftd_code_distributor #(
    parameter int N_STAGES = 2,
    parameter int WORD_W   = 4,
    parameter int CODE_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ilv_mode,
    input  logic                       code_vld,
    input  logic [CODE_W-1:0]          code,
    output logic [N_STAGES*WORD_W-1:0] stage_words,
    output logic                       out_of_range
);
    import ftd_pkg::*;

    localparam int STEP     = full_scale(WORD_W);
    localparam int MAX_CODE = N_STAGES * STEP;
    localparam int BUS_W    = N_STAGES * WORD_W;
    localparam int SUM_W    = CODE_W + 1;

    typedef struct packed {
        logic [BUS_W-1:0] words;
        logic             oor;
    } dist_state_t;

    dist_state_t st_d, st_q;

    logic              code_oor;
    logic [CODE_W-1:0] code_clamped;
    logic [BUS_W-1:0]  seq_words, ilv_words;
    map_mode_e         mode_sel;

    assign code_oor     = int'(code) > MAX_CODE;
    assign code_clamped = code_oor ? CODE_W'(MAX_CODE) : code;
    assign mode_sel     = map_mode_e'(ilv_mode);

    ftd_seq_map #(.N_STAGES(N_STAGES), .WORD_W(WORD_W), .CODE_W(CODE_W)) i_seq_map (
        .code_in   (code_clamped),
        .words_out (seq_words)
    );

    ftd_ilv_map #(.N_STAGES(N_STAGES), .WORD_W(WORD_W), .CODE_W(CODE_W)) i_ilv_map (
        .code_in   (code_clamped),
        .words_out (ilv_words)
    );

    always_comb begin
        st_d = st_q;
        if (code_vld) begin
            st_d.oor   = code_oor;
            st_d.words = (mode_sel == MAP_ILV) ? ilv_words : seq_words;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stage_words  = st_q.words;
    assign out_of_range = st_q.oor;

    logic [SUM_W-1:0] word_sum;
    always_comb begin
        word_sum = '0;
        for (int i = 0; i < N_STAGES; i++)
            word_sum = word_sum + SUM_W'(stage_words[i*WORD_W +: WORD_W]);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (stage_words == '0) && !out_of_range); // R1

    AST_SUM_EQUALS_CODE: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> int'(word_sum) ==
            ((int'($past(code)) > MAX_CODE) ? MAX_CODE : int'($past(code)))); // R2

    AST_OOR_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> out_of_range == (int'($past(code)) > MAX_CODE)); // R4

    AST_OOR_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
        out_of_range |-> (stage_words == {BUS_W{1'b1}})); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> $stable(stage_words) && $stable(out_of_range)); // R5

endmodule

// File: tb/test_ftd_code_distributor.sv
`timescale 1ns/1ps
module test_ftd_code_distributor;

    localparam int N  = 2;
    localparam int W  = 4;
    localparam int CW = 6;
    localparam int FS = (1 << W) - 1;
    localparam int MX = N * FS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ilv_mode = 1'b0;
    logic          code_vld = 1'b0;
    logic [CW-1:0] code = '0;
    logic [N*W-1:0] stage_words;
    logic          out_of_range;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ftd_code_distributor #(.N_STAGES(N), .WORD_W(W), .CODE_W(CW)) i_ftd_code_distributor (
        .clk, .rst, .ilv_mode, .code_vld, .code, .stage_words, .out_of_range
    );

    // {mode, code, expected words, expected flag}
    localparam logic [15:0] VEC_TBL [13] = '{
        {1'b0, 6'd0,  8'h00, 1'b0},   // R3
        {1'b0, 6'd5,  8'h05, 1'b0},   // R6
        {1'b0, 6'd15, 8'h0F, 1'b0},   // R6
        {1'b0, 6'd16, 8'h1F, 1'b0},   // R6
        {1'b0, 6'd30, 8'hFF, 1'b0},   // R3
        {1'b0, 6'd31, 8'hFF, 1'b1},   // R4
        {1'b0, 6'd63, 8'hFF, 1'b1},   // R4
        {1'b1, 6'd0,  8'h00, 1'b0},   // R3
        {1'b1, 6'd1,  8'h01, 1'b0},   // R7
        {1'b1, 6'd2,  8'h11, 1'b0},   // R7
        {1'b1, 6'd3,  8'h12, 1'b0},   // R7
        {1'b1, 6'd29, 8'hEF, 1'b0},   // R7
        {1'b1, 6'd30, 8'hFF, 1'b0}    // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic m, input int c);
        @(negedge clk);
        ilv_mode = m;
        code     = CW'(c);
        code_vld = 1'b1;
        @(negedge clk);
        code_vld = 1'b0;
    endtask

    // step-by-step model: add one unit of load per code step
    function automatic logic [N*W-1:0] model_words(input logic m, input int c);
        int w [N];
        int lim;
        logic [N*W-1:0] r;
        for (int s = 0; s < N; s++) w[s] = 0;
        lim = (c > MX) ? MX : c;
        for (int k = 0; k < lim; k++) begin
            if (m) begin
                w[k % N]++;
            end else begin
                for (int s = 0; s < N; s++) begin
                    if (w[s] < FS) begin
                        w[s]++;
                        break;
                    end
                end
            end
        end
        for (int s = 0; s < N; s++) r[s*W +: W] = W'(w[s]);
        return r;
    endfunction

    function automatic int word_total(input logic [N*W-1:0] v);
        int t = 0;
        for (int s = 0; s < N; s++) t += int'(v[s*W +: W]);
        return t;
    endfunction

    initial begin
        logic [N*W-1:0] held;
        int prev_sum;
        repeat (3) @(negedge clk);
        check("R1 reset words", 32'(stage_words), 32'h0);
        check("R1 reset flag", 32'(out_of_range), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < 13; v++) begin
            apply(VEC_TBL[v][15], int'(VEC_TBL[v][14:9]));
            check("R3/R4/R6/R7 table words", 32'(stage_words), 32'(VEC_TBL[v][8:1]));
            check("R4 table flag", 32'(out_of_range), 32'(VEC_TBL[v][0]));
        end

        for (int m = 0; m < 2; m++) begin
            prev_sum = 0;
            for (int c = 0; c < (1 << CW); c++) begin
                apply(m[0], c);
                check(m ? "R7 sweep" : "R6 sweep", 32'(stage_words), 32'(model_words(m[0], c)));
                check("R4 sweep flag", 32'(out_of_range), 32'(c > MX));
                if (c > 0 && c <= MX)
                    check("R2 unit step", 32'(word_total(stage_words) - prev_sum), 32'd1);
                prev_sum = word_total(stage_words);
            end
        end

        // R5: hold while strobe low
        apply(1'b0, 7);
        held = stage_words;
        @(negedge clk);
        code = CW'(22); ilv_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 hold words", 32'(stage_words), 32'(held));
        check("R5 hold flag", 32'(out_of_range), 32'h0);

        // R8: mode captured per strobe
        apply(1'b0, 20);
        check("R8 seq capture", 32'(stage_words), 32'h5F);
        apply(1'b1, 20);
        check("R8 ilv capture", 32'(stage_words), 32'hAA);

        // R4: flag clears on a legal code
        apply(1'b1, 40);
        check("R4 clamp flag", 32'(out_of_range), 32'h1);
        apply(1'b1, 4);
        check("R4 flag clears", 32'(out_of_range), 32'h0);
        check("R4 legal words", 32'(stage_words), 32'h22);

        // R1: reset mid-run
        apply(1'b0, 63);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset words", 32'(stage_words), 32'h0);
        check("R1 mid reset flag", 32'(out_of_range), 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule